// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block fetches a board configuration image from a bit-serial EEPROM as soon as reset is released. It drives a select line, a serial clock and a command data line toward the memory, and it samples the data line coming back. Every one of the 64 sixteen-bit words is fetched by its own read command. All words are kept in an internal buffer, and a running 16-bit checksum is formed over them.

After the last word, the block judges the image. A good image supplies three settings to the rest of the chip: the host bus identifier, the tagged command queue depth and the active bus negation enable. A bad image leaves safe defaults in place. In both cases the block then raises a completion flag that stays high until the next reset. The flag tells the rest of the chip whether the three settings came from the memory.

Every step of the serial waveform lasts one phase. One phase is a parameterised number of system clocks, nominally 160 µs. The whole fetch is slow and runs only once per reset.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is asserted, and after reset until the load completes, select, serial clock and command data are low, `load_done` and `image_valid` are low, `host_id` is 7, `tag_depth` is 0 and `act_neg_en` is 0.
- R2: Words are fetched in address order 0 to 63. The command for word n is a 9-bit frame, sent most significant bit first: a start bit of 1 followed by the 8-bit value 0x80 + n.
- R3: Each command bit takes three phases. In the first, data is set while the clock is low. In the second, the clock is high while the data is held. In the third, both are low. Data never changes on a clock rise.
- R4: After the command, 16 data bits are read most significant bit first. Each bit takes one phase with the clock high and one with the clock low. The data-in line is sampled at the end of the low phase.
- R5: For each word, select rises with clock and data low for one phase before the command, stays high through the data bits, and then drops for one phase with all lines idle. Whenever select is low, clock and data are low.
- R6: After reset, one idle phase comes before word 0. Every phase lasts exactly CLKS_PER_PHASE clocks.
- R7: `load_done` rises CLKS_PER_PHASE × (1 + 64 × 61) clocks after reset is released. It then stays high, the serial lines stay idle, and the result outputs no longer change.
- R8: `image_valid` is high after completion only when the 16-bit wrapping sum of all 64 words equals 0x1234.
- R9: On a valid image, bytes are numbered little-endian (byte 2k is bits 7:0 of word k, byte 2k+1 is bits 15:8). `host_id` is byte 0x40. `tag_depth` is 2 shifted left by byte 0x43, truncated to 16 bits. `act_neg_en` is bit 3 of byte 0x41.
- R10: On an invalid image, completion still occurs, with `host_id` 7, `tag_depth` 0, `act_neg_en` 0 and `image_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; a load starts on its release |
| ser_miso | input | 1 | Data returned by the serial memory |
| ser_cs | output | 1 | Memory select, high active |
| ser_clk | output | 1 | Serial clock to the memory |
| ser_mosi | output | 1 | Command data to the memory |
| load_done | output | 1 | Load finished (sticky until reset) |
| image_valid | output | 1 | Image checksum matched |
| host_id | output | 8 | Host bus identifier |
| tag_depth | output | 16 | Tagged command queue depth |
| act_neg_en | output | 1 | Active bus negation enable |

## Verification
The bench builds the loader with CLKS_PER_PHASE = 2. A full 3905-phase load then fits in under 8000 clocks, while the phase-to-phase timing stays visible: each phase spans two clocks, so a timer that is off by one moves every later edge. The word count, word width, command base, checksum target and byte offsets keep their defaults. As a result, the real image layout, the 0x1234 check and the shift decode of the depth byte are covered, including one depth byte of 14 that lands on the top bit of the 16-bit field.

// File: rtl/cel_pkg.sv
package cel_pkg;

    // Sequencer macro states
    typedef enum logic [2:0] {
        ST_START,
        ST_SELECT,
        ST_CMD,
        ST_DATA,
        ST_RELEASE,
        ST_FINISH
    } seq_state_e;

    // Sub-step inside a bit; command bits use A/B/C, data bits use A/B
    typedef enum logic [1:0] {
        STEP_A,
        STEP_B,
        STEP_C
    } step_e;

endpackage

// File: rtl/cel_phase_timer.sv
module cel_phase_timer #(
    parameter int CLKS_PER_PHASE = 6400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (CLKS_PER_PHASE > 1) ? $clog2(CLKS_PER_PHASE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_PHASE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (run) begin
            if (cnt_q == CNT_LAST) begin
                tick  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cel_bit_sequencer.sv
module cel_bit_sequencer
    import cel_pkg::*;
#(
    parameter int WORD_COUNT = 64,
    parameter int WORD_BITS  = 16,
    parameter int CMD_BITS   = 8,
    parameter int CMD_BASE   = 'h80,
    localparam int ADDR_W    = $clog2(WORD_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 ser_miso,
    output logic                 ser_cs,
    output logic                 ser_clk,
    output logic                 ser_mosi,
    output logic                 word_we,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 image_end
);
    localparam int FRAME_W = CMD_BITS + 1;
    localparam int BIT_W   = $clog2(CMD_BITS + WORD_BITS + 1);
    localparam logic [BIT_W-1:0]  CMD_LAST  = BIT_W'(CMD_BITS);
    localparam logic [BIT_W-1:0]  DATA_LAST = BIT_W'(WORD_BITS - 1);
    localparam logic [ADDR_W-1:0] WORD_LAST = ADDR_W'(WORD_COUNT - 1);

    typedef struct packed {
        seq_state_e             state;
        step_e                  step;
        logic [BIT_W-1:0]       bit_idx;
        logic [ADDR_W-1:0]      word;
        logic [WORD_BITS-2:0]   shreg;
    } seq_regs_t;

    seq_regs_t d, q;

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] frame_sh;
    logic               frame_bit;

    // Start bit, then the command value for the current word, MSB first
    always_comb begin
        frame     = {1'b1, CMD_BITS'(CMD_BASE) + CMD_BITS'(q.word)};
        frame_sh  = frame << q.bit_idx;
        frame_bit = frame_sh[FRAME_W-1];
    end

    // Line decode from registered state
    always_comb begin
        ser_cs   = (q.state == ST_SELECT) || (q.state == ST_CMD) || (q.state == ST_DATA);
        ser_clk  = ((q.state == ST_CMD)  && (q.step == STEP_B)) ||
                   ((q.state == ST_DATA) && (q.step == STEP_A));
        ser_mosi = (q.state == ST_CMD) && (q.step != STEP_C) && frame_bit;
    end

    assign word_addr = q.word;
    assign word_data = {q.shreg, ser_miso};

    always_comb begin
        d         = q;
        word_we   = 1'b0;
        image_end = 1'b0;
        if (tick) begin
            unique case (q.state)
                ST_START: begin
                    d.state = ST_SELECT;
                    d.word  = '0;
                end
                ST_SELECT: begin
                    d.state   = ST_CMD;
                    d.step    = STEP_A;
                    d.bit_idx = '0;
                end
                ST_CMD: begin
                    unique case (q.step)
                        STEP_A: d.step = STEP_B;
                        STEP_B: d.step = STEP_C;
                        default: begin
                            d.step = STEP_A;
                            if (q.bit_idx == CMD_LAST) begin
                                d.state   = ST_DATA;
                                d.bit_idx = '0;
                            end else begin
                                d.bit_idx = q.bit_idx + 1'b1;
                            end
                        end
                    endcase
                end
                ST_DATA: begin
                    if (q.step == STEP_A) begin
                        d.step = STEP_B;
                    end else begin
                        d.step  = STEP_A;
                        d.shreg = {q.shreg[WORD_BITS-3:0], ser_miso};
                        if (q.bit_idx == DATA_LAST) begin
                            word_we = 1'b1;
                            d.state = ST_RELEASE;
                        end else begin
                            d.bit_idx = q.bit_idx + 1'b1;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (q.word == WORD_LAST) begin
                        d.state   = ST_FINISH;
                        image_end = 1'b1;
                    end else begin
                        d.state = ST_SELECT;
                        d.word  = q.word + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_START;
            q.step    <= STEP_A;
            q.bit_idx <= '0;
            q.word    <= '0;
            q.shreg   <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cel_image_store.sv
module cel_image_store #(
    parameter int WORD_COUNT  = 64,
    parameter int WORD_BITS   = 16,
    parameter int CHECK_VALUE = 'h1234,
    parameter int ID_BYTE     = 'h40,
    parameter int NEG_BYTE    = 'h41,
    parameter int NEG_BIT     = 3,
    parameter int TAG_BYTE    = 'h43,
    parameter int TAG_W       = 16,
    parameter int DEFAULT_ID  = 7,
    localparam int ADDR_W     = $clog2(WORD_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [WORD_BITS-1:0] wdata,
    input  logic                 commit,
    output logic                 done,
    output logic                 valid,
    output logic [7:0]           host_id,
    output logic [TAG_W-1:0]     tag_depth,
    output logic                 act_neg
);
    localparam int BPW = WORD_BITS / 8;

    typedef struct packed {
        logic [WORD_BITS-1:0] sum;
        logic                 done;
        logic                 valid;
        logic [7:0]           id;
        logic [TAG_W-1:0]     tag;
        logic                 neg;
    } store_regs_t;

    store_regs_t d, q;

    logic [WORD_BITS-1:0] buf_q [WORD_COUNT];

    logic [7:0] id_byte;
    logic [7:0] tag_byte;
    logic       neg_bit;

    // Little-endian byte lanes inside each stored word
    always_comb begin
        id_byte  = buf_q[ID_BYTE / BPW][(ID_BYTE % BPW) * 8 +: 8];
        tag_byte = buf_q[TAG_BYTE / BPW][(TAG_BYTE % BPW) * 8 +: 8];
        neg_bit  = buf_q[NEG_BYTE / BPW][(NEG_BYTE % BPW) * 8 + NEG_BIT];
    end

    always_comb begin
        d = q;
        if (we) d.sum = q.sum + wdata;
        if (commit) begin
            d.done = 1'b1;
            if (q.sum == WORD_BITS'(CHECK_VALUE)) begin
                d.valid = 1'b1;
                d.id    = id_byte;
                d.tag   = TAG_W'(2) << tag_byte;
                d.neg   = neg_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sum   <= '0;
            q.done  <= 1'b0;
            q.valid <= 1'b0;
            q.id    <= 8'(DEFAULT_ID);
            q.tag   <= '0;
            q.neg   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) buf_q[waddr] <= wdata;
    end

    assign done      = q.done;
    assign valid     = q.valid;
    assign host_id   = q.id;
    assign tag_depth = q.tag;
    assign act_neg   = q.neg;

endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
    parameter int CLKS_PER_PHASE = 6400,
    parameter int WORD_COUNT     = 64,
    parameter int WORD_BITS      = 16,
    parameter int CMD_BITS       = 8,
    parameter int CMD_BASE       = 'h80,
    parameter int CHECK_VALUE    = 'h1234,
    parameter int ID_BYTE        = 'h40,
    parameter int NEG_BYTE       = 'h41,
    parameter int NEG_BIT        = 3,
    parameter int TAG_BYTE       = 'h43,
    parameter int TAG_W          = 16,
    parameter int DEFAULT_ID     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_miso,
    output logic             ser_cs,
    output logic             ser_clk,
    output logic             ser_mosi,
    output logic             load_done,
    output logic             image_valid,
    output logic [7:0]       host_id,
    output logic [TAG_W-1:0] tag_depth,
    output logic             act_neg_en
);
    localparam int ADDR_W = $clog2(WORD_COUNT);

    logic                 tick;
    logic                 word_we;
    logic [ADDR_W-1:0]    word_addr;
    logic [WORD_BITS-1:0] word_data;
    logic                 image_end;

    cel_phase_timer #(
        .CLKS_PER_PHASE(CLKS_PER_PHASE)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (!load_done),
        .tick (tick)
    );

    cel_bit_sequencer #(
        .WORD_COUNT(WORD_COUNT),
        .WORD_BITS (WORD_BITS),
        .CMD_BITS  (CMD_BITS),
        .CMD_BASE  (CMD_BASE)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ser_miso (ser_miso),
        .ser_cs   (ser_cs),
        .ser_clk  (ser_clk),
        .ser_mosi (ser_mosi),
        .word_we  (word_we),
        .word_addr(word_addr),
        .word_data(word_data),
        .image_end(image_end)
    );

    cel_image_store #(
        .WORD_COUNT (WORD_COUNT),
        .WORD_BITS  (WORD_BITS),
        .CHECK_VALUE(CHECK_VALUE),
        .ID_BYTE    (ID_BYTE),
        .NEG_BYTE   (NEG_BYTE),
        .NEG_BIT    (NEG_BIT),
        .TAG_BYTE   (TAG_BYTE),
        .TAG_W      (TAG_W),
        .DEFAULT_ID (DEFAULT_ID)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (word_we),
        .waddr    (word_addr),
        .wdata    (word_data),
        .commit   (image_end),
        .done     (load_done),
        .valid    (image_valid),
        .host_id  (host_id),
        .tag_depth(tag_depth),
        .act_neg  (act_neg_en)
    );

endmodule

// File: rtl/cel_checker.sv
module cel_checker #(
    parameter int TAG_W      = 16,
    parameter int DEFAULT_ID = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_cs,
    input logic             ser_clk,
    input logic             ser_mosi,
    input logic             load_done,
    input logic             image_valid,
    input logic [7:0]       host_id,
    input logic [TAG_W-1:0] tag_depth,
    input logic             act_neg_en
);

    a_r5_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cs |-> (!ser_clk && !ser_mosi));

    a_r3_data_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_mosi));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !ser_cs);

    a_r7_results_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> ($stable(host_id) && $stable(tag_depth) &&
                       $stable(act_neg_en) && $stable(image_valid)));

    a_r8_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        image_valid |-> load_done);

    a_r9_depth_power_of_two: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tag_depth));

    a_r10_fallback_values: assert property (@(posedge clk) disable iff (!rst_n)
        !image_valid |-> (host_id == 8'(DEFAULT_ID) && tag_depth == '0 && !act_neg_en));

endmodule

bind cfg_eeprom_loader cel_checker #(
    .TAG_W     (TAG_W),
    .DEFAULT_ID(DEFAULT_ID)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_cs     (ser_cs),
    .ser_clk    (ser_clk),
    .ser_mosi   (ser_mosi),
    .load_done  (load_done),
    .image_valid(image_valid),
    .host_id    (host_id),
    .tag_depth  (tag_depth),
    .act_neg_en (act_neg_en)
);

// File: tb/cfg_eeprom_loader_tb_top.sv
module cfg_eeprom_loader_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int PHASE_CLKS  = 2;
    localparam int NWORDS      = 64;
    localparam int WORD_PHASES = 61;
    localparam int ALL_PHASES  = 1 + NWORDS * WORD_PHASES;
    localparam int DONE_CYC    = ALL_PHASES * PHASE_CLKS;
    localparam int TAIL        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_miso;
    logic        ser_cs, ser_clk, ser_mosi;
    logic        load_done, image_valid, act_neg_en;
    logic [7:0]  host_id;
    logic [15:0] tag_depth;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_eeprom_loader #(
        .CLKS_PER_PHASE(PHASE_CLKS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_miso   (ser_miso),
        .ser_cs     (ser_cs),
        .ser_clk    (ser_clk),
        .ser_mosi   (ser_mosi),
        .load_done  (load_done),
        .image_valid(image_valid),
        .host_id    (host_id),
        .tag_depth  (tag_depth),
        .act_neg_en (act_neg_en)
    );

    // Serial memory image and behavioural memory model
    logic [15:0] img [NWORDS];

    logic        ee_din;
    int          ee_bits;
    int          ee_word;
    logic [8:0]  ee_frame;
    logic [15:0] ee_out;
    int          ee_checks = 0;
    int          ee_fails  = 0;

    assign ser_miso = ee_din;

    always @(posedge ser_clk or negedge ser_cs or negedge rst_n) begin
        if (!rst_n) begin
            ee_bits = 0;
            ee_word = 0;
            ee_din  = 1'b0;
        end else if (!ser_cs) begin
            ee_bits = 0;
            ee_din  = 1'b0;
        end else begin
            if (ee_bits < 9) begin
                ee_frame = {ee_frame[7:0], ser_mosi};
                if (ee_bits == 8) begin
                    // R2: start bit then 0x80 + word index, words in order
                    ee_checks++;
                    if (ee_frame != {1'b1, 8'(8'h80 + ee_word)}) begin
                        ee_fails++;
                        $display("FAIL R2 command frame: actual %h expected %h",
                                 ee_frame, {1'b1, 8'(8'h80 + ee_word)});
                    end
                    ee_out = img[ee_frame[5:0]];
                    ee_word++;
                end
            end else if (ee_bits < 25) begin
                ee_din = ee_out[15 - (ee_bits - 9)];
            end
            ee_bits++;
        end
    end

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Expected results from the loaded image
    logic        exp_valid;
    logic [7:0]  exp_id;
    logic [15:0] exp_tag;
    logic        exp_neg;

    task automatic predict();
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < NWORDS; i++) s = s + img[i];
        exp_valid = (s == 16'h1234);
        if (exp_valid) begin
            exp_id  = img[32][7:0];
            exp_neg = img[32][11];
            exp_tag = 16'(32'd2 << img[33][15:8]);
        end else begin
            exp_id  = 8'd7;
            exp_neg = 1'b0;
            exp_tag = 16'd0;
        end
    endtask

    task automatic build_image(input logic [7:0] id, input logic [7:0] neg_byte,
                               input logic [7:0] tag_byte, input bit good);
        logic [15:0] s;
        for (int i = 0; i < NWORDS; i++) img[i] = 16'($urandom);
        img[32] = {neg_byte, id};
        img[33] = {tag_byte, img[33][7:0]};
        s = '0;
        for (int i = 0; i < NWORDS - 1; i++) s = s + img[i];
        img[NWORDS-1] = 16'h1234 - s;
        if (!good) img[NWORDS-1] = img[NWORDS-1] + 16'd1;
    endtask

    // Behavioural line model: cycle k after reset release
    task automatic compare(input int k);
        int   p, q, w, r, i, s;
        logic ecs, eclk, emosi, edone;
        logic [8:0] fr;
        string ctag;
        ecs = 0; eclk = 0; emosi = 0;
        ctag = "R5/R6";
        p = k / PHASE_CLKS;                // R6: phase length
        if (p >= 1 && p < ALL_PHASES) begin
            q = p - 1;
            w = q / WORD_PHASES;
            r = q % WORD_PHASES;
            fr = {1'b1, 8'(8'h80 + w)};
            if (r == 0) begin
                ecs = 1;
            end else if (r <= 27) begin
                i = (r - 1) / 3;
                s = (r - 1) % 3;
                ecs = 1;
                eclk = (s == 1);
                emosi = (s != 2) && fr[8 - i];
                ctag = "R3";
            end else if (r <= 59) begin
                ecs = 1;
                eclk = (((r - 28) % 2) == 0);
                ctag = "R4";
            end
        end
        edone = (k >= DONE_CYC);
        check(ser_cs === ecs, "R5/R6 select", int'(ser_cs), int'(ecs));
        check(ser_clk === eclk, {ctag, " serial clock"}, int'(ser_clk), int'(eclk));
        check(ser_mosi === emosi, "R3 command data", int'(ser_mosi), int'(emosi));
        check(load_done === edone, "R7 done timing", int'(load_done), int'(edone));
        if (!edone) begin
            check(image_valid === 1'b0 && host_id === 8'd7 && tag_depth === 16'd0 &&
                  act_neg_en === 1'b0, "R1 pre-completion outputs",
                  int'({image_valid, host_id, tag_depth, act_neg_en}), 'h70000 << 1);
        end else begin
            check(image_valid === exp_valid, "R8 checksum verdict",
                  int'(image_valid), int'(exp_valid));
            check(host_id === exp_id, exp_valid ? "R9 host id" : "R10 host id",
                  int'(host_id), int'(exp_id));
            check(tag_depth === exp_tag, exp_valid ? "R9 tag depth" : "R10 tag depth",
                  int'(tag_depth), int'(exp_tag));
            check(act_neg_en === exp_neg, exp_valid ? "R9 negation" : "R10 negation",
                  int'(act_neg_en), int'(exp_neg));
        end
    endtask

    task automatic run_load();
        rst_n = 1'b0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            // R1: reset state
            check(ser_cs === 0 && ser_clk === 0 && ser_mosi === 0 && load_done === 0,
                  "R1 reset lines", int'({ser_cs, ser_clk, ser_mosi, load_done}), 0);
            check(image_valid === 0 && host_id === 8'd7 && tag_depth === 0 && act_neg_en === 0,
                  "R1 reset results", int'(host_id), 7);
        end
        predict();
        rst_n = 1'b1;
        for (int k = 0; k < DONE_CYC + TAIL; k++) begin
            compare(k);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed",
                 (n_checks + ee_checks) - (n_fails + ee_fails) - 1, n_checks + ee_checks + 1);
        $finish;
    end

    initial begin
        // Valid image, negation on, depth byte 3
        build_image(8'h05, 8'h08, 8'h03, 1'b1);
        run_load();
        // Valid image, negation off, depth byte 14 reaches the top bit
        build_image(8'hA5, 8'hF7, 8'h0E, 1'b1);
        run_load();
        // Checksum off by one: fallback values
        build_image(8'h02, 8'hFF, 8'h02, 1'b0);
        run_load();
        $display("%0d/%0d checks passed",
                 (n_checks + ee_checks) - (n_fails + ee_fails), n_checks + ee_checks);
        $finish;
    end

endmodule